// File: doc/BRIEF.md
# Halfword and Signed-Byte Load/Store Unit

This unit executes the halfword and sign-extending transfer class of a 32-bit RISC core. The core hands it one instruction word, the result of the condition check, and the values already read from the base, offset and source registers. The unit decodes the word and forms the transfer address. The offset is either an 8-bit immediate split across two nibbles or a register, and it is added or subtracted before or after the access. The unit then runs one access on a word-wide memory port with byte-lane enables.

When the access completes, the unit returns the loaded value, zero- or sign-extended, to the destination register. It also returns the updated base value and the write enables for both registers. Words outside this class (the swap pattern, or wrong fixed bits) are reported and not executed. Illegal combinations and misaligned halfword addresses are also reported and not executed. Lanes are mapped little-endian only.

Top module: `hsx_unit`

## Requirements
- R1: When `cond_pass` is 0 at `start`, no memory request is issued and neither register write fires; `done` is high in the cycle after `start`, with all flags low.
- R2: A word whose bits 27:25 are not 000, whose bit 7 or bit 4 is 0, or whose bits 6:5 are 00 raises `not_class` together with `done` one cycle after `start`, with no access and no register write.
- R3: Bit 22 = 1 uses the offset {instr[11:8], instr[3:0]}; bit 22 = 0 uses `ofs_val`, and in that case nonzero bits 11:8 raise `illegal`.
- R4: Bit 23 = 1 adds the offset to `base_val`, 0 subtracts it; bit 24 = 1 issues the access at the modified base, 0 at the unmodified base.
- R5: The modified base is written to Rn (bits 19:16) when bit 24 = 1 and bit 21 = 1, and always when bit 24 = 0; bit 24 = 1 with bit 21 = 0 writes nothing; bit 24 = 0 with bit 21 = 1 raises `illegal`.
- R6: A store (bit 20 = 0) with bits 6:5 = 01 drives `src_val[15:0]` on both halves of `mem_wdata`, with `mem_be` = 1100 when address bit 1 is 1 and 0011 when it is 0.
- R7: A store with bit 6 = 1 raises `illegal` and performs no memory access.
- R8: A load with bits 6:5 = 01 returns the halfword selected by address bit 1, with bits 31:16 set to zero.
- R9: A load with bits 6:5 = 10 returns the byte selected by address bits 1:0, with bits 31:8 copies of its bit 7, and `mem_be` enables only that byte.
- R10: A load with bits 6:5 = 11 returns the selected halfword, with bits 31:16 copies of its bit 15.
- R11: A halfword access at an odd address raises `misaligned` with `done`, and performs no access and no register write.
- R12: `mem_req` and the request fields stay stable until `mem_ready` is sampled high. In the next cycle `done` pulses and the load result is written to Rd (bits 15:12).
- R13: A load whose Rd equals Rn writes the loaded value to Rd and suppresses the base write-back.
- R14: A synchronous active-high `rst` returns the unit to idle with `mem_req`, `mem_we`, `mem_be`, both register write enables, `done` and all flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse presenting a new instruction |
| instr | input | 32 | Instruction word |
| cond_pass | input | 1 | Condition check result for this instruction |
| base_val | input | 32 | Value of the base register |
| ofs_val | input | 32 | Value of the offset register |
| src_val | input | 32 | Value of the source register for stores |
| mem_req | output | 1 | Memory request, held until ready |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the request |
| rd_we | output | 1 | Destination register write enable |
| rd_idx | output | 4 | Destination register number |
| rd_data | output | 32 | Extended load result |
| rn_we | output | 1 | Base register write enable |
| rn_idx | output | 4 | Base register number |
| rn_data | output | 32 | Modified base value |
| not_class | output | 1 | Word is outside this instruction class |
| illegal | output | 1 | Illegal field combination |
| misaligned | output | 1 | Halfword access at an odd address |
| done | output | 1 | Instruction finished |
| busy | output | 1 | Unit is not idle |

## Verification
On every cycle, the assertions check the following:
- a request only starts from an accepted `start`, and it holds still while it waits;
- a store enables exactly one aligned halfword;
- `done` is a single pulse;
- a flagged instruction never writes a register;
- the Rd/Rn write-back conflict is always resolved toward Rd;
- a signed byte result is always a true sign extension.

Only the bench's scenarios can show the rest. These are the arithmetic of the address and the new base for each indexing choice, and which lane is picked for each address. They also cover the zero versus sign fill for concrete data and the classification of each illegal or foreign encoding.

// File: rtl/hsx_pkg.sv
package hsx_pkg;
    localparam int XLEN   = 32;
    localparam int NBYTE  = XLEN / 8;
    localparam int NHALF  = XLEN / 16;
    localparam int RIDX_W = 4;
    localparam int BOFS_W = $clog2(NBYTE);

    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_REQ = 2'd1, ST_FIN = 2'd2} st_e;
    typedef enum logic [1:0] {K_SWP = 2'd0, K_UH = 2'd1, K_SB = 2'd2, K_SH = 2'd3} kind_e;

    typedef struct packed {
        logic              skip;
        logic              nc;
        logic              ill;
        logic              mis;
        logic              ld;
        logic              wb;
        kind_e             kind;
        logic [RIDX_W-1:0] rd;
        logic [RIDX_W-1:0] rn;
        logic [XLEN-1:0]   addr;
        logic [XLEN-1:0]   nbase;
    } dec_t;

    typedef struct packed {
        st_e               st;
        logic              xfer;
        logic              ld;
        logic              wb;
        logic              nc;
        logic              ill;
        logic              mis;
        kind_e             kind;
        logic [RIDX_W-1:0] rd;
        logic [RIDX_W-1:0] rn;
        logic [NBYTE-1:0]  be;
        logic [XLEN-1:0]   addr;
        logic [XLEN-1:0]   nbase;
        logic [XLEN-1:0]   wdata;
        logic [XLEN-1:0]   rdat;
    } regs_t;
endpackage

// File: rtl/hsx_decode.sv
module hsx_decode
    import hsx_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    input  logic            cond_pass,
    input  logic [XLEN-1:0] base_val,
    input  logic [XLEN-1:0] ofs_val,
    output dec_t            dec
);
    logic            pre, up, imm, wbit, ld, sgn;
    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] moved;

    always_comb begin
        pre    = instr[24];
        up     = instr[23];
        imm    = instr[22];
        wbit   = instr[21];
        ld     = instr[20];
        sgn    = instr[6];
        offset = imm ? {{(XLEN-8){1'b0}}, instr[11:8], instr[3:0]} : ofs_val;
        moved  = up ? (base_val + offset) : (base_val - offset);

        dec       = '0;
        dec.skip  = !cond_pass;
        dec.nc    = (instr[27:25] != 3'b000) || !instr[7] || !instr[4] ||
                    (instr[6:5] == 2'b00);
        dec.ill   = (!ld && sgn) || (!pre && wbit) ||
                    (!imm && (instr[11:8] != 4'h0));
        dec.kind  = kind_e'(instr[6:5]);
        dec.ld    = ld;
        dec.wb    = !pre || wbit;
        dec.rd    = instr[15:12];
        dec.rn    = instr[19:16];
        dec.addr  = pre ? moved : base_val;
        dec.nbase = moved;
        dec.mis   = (dec.kind != K_SB) && dec.addr[0];
    end
endmodule

// File: rtl/hsx_store_lane.sv
module hsx_store_lane
    import hsx_pkg::*;
(
    input  kind_e             kind,
    input  logic [BOFS_W-1:0] alo,
    input  logic [XLEN-1:0]   src,
    output logic [NBYTE-1:0]  be,
    output logic [XLEN-1:0]   wdata
);
    always_comb begin
        wdata = {NHALF{src[15:0]}};
        be    = '0;
        if (kind == K_SB) begin
            be[alo] = 1'b1;
        end else begin
            be[{alo[BOFS_W-1:1], 1'b0}]     = 1'b1;
            be[{alo[BOFS_W-1:1], 1'b0} + 1] = 1'b1;
        end
    end
endmodule

// File: rtl/hsx_load_lane.sv
module hsx_load_lane
    import hsx_pkg::*;
(
    input  kind_e             kind,
    input  logic [BOFS_W-1:0] alo,
    input  logic [XLEN-1:0]   rdata,
    output logic [XLEN-1:0]   ext
);
    logic [7:0]  bytes [NBYTE];
    logic [15:0] halves [NHALF];

    for (genvar i = 0; i < NBYTE; i++) begin : g_byte
        assign bytes[i] = rdata[8*i +: 8];
    end
    for (genvar j = 0; j < NHALF; j++) begin : g_half
        assign halves[j] = rdata[16*j +: 16];
    end

    logic [7:0]  bsel;
    logic [15:0] hsel;

    always_comb begin
        bsel = bytes[alo];
        hsel = halves[alo[BOFS_W-1:1]];
        unique case (kind)
            K_SB:    ext = {{(XLEN-8){bsel[7]}}, bsel};
            K_SH:    ext = {{(XLEN-16){hsel[15]}}, hsel};
            default: ext = {{(XLEN-16){1'b0}}, hsel};
        endcase
    end
endmodule

// File: rtl/hsx_unit.sv
module hsx_unit
    import hsx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] instr,
    input  logic        cond_pass,
    input  logic [31:0] base_val,
    input  logic [31:0] ofs_val,
    input  logic [31:0] src_val,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [3:0]  mem_be,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ready,
    output logic        rd_we,
    output logic [3:0]  rd_idx,
    output logic [31:0] rd_data,
    output logic        rn_we,
    output logic [3:0]  rn_idx,
    output logic [31:0] rn_data,
    output logic        not_class,
    output logic        illegal,
    output logic        misaligned,
    output logic        done,
    output logic        busy
);
    dec_t            dec;
    regs_t           r_d, r_q;
    logic [NBYTE-1:0] st_be;
    logic [XLEN-1:0]  st_wdata;
    logic [XLEN-1:0]  ld_ext;

    hsx_decode u_dec (
        .instr     (instr),
        .cond_pass (cond_pass),
        .base_val  (base_val),
        .ofs_val   (ofs_val),
        .dec       (dec)
    );

    hsx_store_lane u_st (
        .kind  (dec.kind),
        .alo   (dec.addr[BOFS_W-1:0]),
        .src   (src_val),
        .be    (st_be),
        .wdata (st_wdata)
    );

    hsx_load_lane u_ld (
        .kind  (r_q.kind),
        .alo   (r_q.addr[BOFS_W-1:0]),
        .rdata (mem_rdata),
        .ext   (ld_ext)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.kind  = dec.kind;
                    r_d.rd    = dec.rd;
                    r_d.rn    = dec.rn;
                    r_d.addr  = dec.addr;
                    r_d.nbase = dec.nbase;
                    r_d.be    = st_be;
                    r_d.wdata = st_wdata;
                    r_d.ld    = dec.ld;
                    r_d.wb    = dec.wb;
                    r_d.nc    = 1'b0;
                    r_d.ill   = 1'b0;
                    r_d.mis   = 1'b0;
                    r_d.xfer  = 1'b0;
                    r_d.st    = ST_FIN;
                    if (dec.skip) begin
                        r_d.xfer = 1'b0;
                    end else if (dec.nc) begin
                        r_d.nc = 1'b1;
                    end else if (dec.ill) begin
                        r_d.ill = 1'b1;
                    end else if (dec.mis) begin
                        r_d.mis = 1'b1;
                    end else begin
                        r_d.xfer = 1'b1;
                        r_d.st   = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                if (mem_ready) begin
                    r_d.rdat = ld_ext;
                    r_d.st   = ST_FIN;
                end
            end
            default: begin
                r_d.st   = ST_IDLE;
                r_d.xfer = 1'b0;
                r_d.nc   = 1'b0;
                r_d.ill  = 1'b0;
                r_d.mis  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    always_comb begin
        busy       = (r_q.st != ST_IDLE);
        mem_req    = (r_q.st == ST_REQ);
        mem_we     = mem_req && !r_q.ld;
        mem_be     = mem_req ? r_q.be : '0;
        mem_addr   = r_q.addr;
        mem_wdata  = r_q.wdata;
        done       = (r_q.st == ST_FIN);
        not_class  = done && r_q.nc;
        illegal    = done && r_q.ill;
        misaligned = done && r_q.mis;
        rd_we      = done && r_q.xfer && r_q.ld;
        rd_idx     = r_q.rd;
        rd_data    = r_q.rdat;
        rn_we      = done && r_q.xfer && r_q.wb && !(r_q.ld && (r_q.rd == r_q.rn));
        rn_idx     = r_q.rn;
        rn_data    = r_q.nbase;
    end

    // R12: a request only begins after an accepted start
    p_req_from_start_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> $past(start));
    // R12: a waiting request keeps its fields
    p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_be)
                                     && $stable(mem_we) && $stable(mem_wdata)));
    // R6: a store enables one aligned halfword
    p_store_lanes_r6: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_be == 4'b0011 || mem_be == 4'b1100));
    // R12: done lasts exactly one cycle
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R7, R11, R2: a flagged instruction writes no register
    p_flag_nowrite_r7: assert property (@(posedge clk) disable iff (rst)
        (illegal || misaligned || not_class) |-> (!rd_we && !rn_we));
    // R13: never both writes to the same register
    p_rd_wins_r13: assert property (@(posedge clk) disable iff (rst)
        (rd_we && rn_we) |-> (rd_idx != rn_idx));
    // R9: a signed byte result is a true sign extension
    p_sext_byte_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_we && r_q.kind == K_SB) |-> (rd_data[31:8] == {24{rd_data[7]}}));
endmodule

// File: tb/hsx_unit_bench.sv
`timescale 1ns/1ps
module hsx_unit_bench;
    logic        clk = 1'b0;
    logic        rst, start, cond_pass, mem_ready;
    logic [31:0] instr, base_val, ofs_val, src_val, mem_rdata;
    logic        mem_req, mem_we, rd_we, rn_we, not_class, illegal, misaligned, done, busy;
    logic [31:0] mem_addr, mem_wdata, rd_data, rn_data;
    logic [3:0]  mem_be, rd_idx, rn_idx;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    hsx_unit u_hsx_unit (.*);

    // observed results of one instruction
    logic        o_req, o_we, o_stable, o_done, o_rdwe, o_rnwe, o_ill, o_nc, o_ma;
    logic [31:0] o_addr, o_wdata, o_rddata, o_rndata;
    logic [3:0]  o_be, o_rdidx, o_rnidx;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit p, u, i, w, l, input logic [3:0] rn, rd,
                                       input bit s, h, input logic [7:0] off);
        mk = {4'hE, 3'b000, p, u, i, w, l, rn, rd, off[7:4], 1'b1, s, h, 1'b1, off[3:0]};
    endfunction

    task automatic exec(input logic [31:0] iw, input logic cp, input logic [31:0] b,
                        input logic [31:0] o, input logic [31:0] s,
                        input logic [31:0] rdat, input int waitn);
        @(negedge clk);
        instr = iw; cond_pass = cp; base_val = b; ofs_val = o; src_val = s; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        o_req = mem_req; o_stable = 1'b1;
        o_addr = mem_addr; o_be = mem_be; o_we = mem_we; o_wdata = mem_wdata;
        if (mem_req) begin
            for (int k = 0; k < waitn; k++) begin
                @(posedge clk); #1;
                if (!mem_req || mem_addr !== o_addr || mem_be !== o_be || done) o_stable = 1'b0;
            end
            mem_ready = 1'b1; mem_rdata = rdat;
            @(posedge clk); #1;
            mem_ready = 1'b0; mem_rdata = 32'h0;
        end
        o_done = done; o_rdwe = rd_we; o_rddata = rd_data; o_rdidx = rd_idx;
        o_rnwe = rn_we; o_rndata = rn_data; o_rnidx = rn_idx;
        o_ill = illegal; o_nc = not_class; o_ma = misaligned;
        @(posedge clk); #1;
        chk("R12 done single pulse", {31'b0, done}, 32'd0);
    endtask

    task automatic t_reset;
        chk("R14 mem_req", {31'b0, mem_req}, 0);
        chk("R14 mem_we", {31'b0, mem_we}, 0);
        chk("R14 mem_be", {28'b0, mem_be}, 0);
        chk("R14 writes", {30'b0, rd_we, rn_we}, 0);
        chk("R14 done/flags", {28'b0, done, illegal, misaligned, not_class}, 0);
        chk("R14 busy", {31'b0, busy}, 0);
    endtask

    task automatic t_cond_false;
        exec(mk(1,1,1,1,1,4'd1,4'd2,0,1,8'h10), 1'b0, 32'h100, 0, 0, 32'hFFFF_FFFF, 0);
        chk("R1 no request", {31'b0, o_req}, 0);
        chk("R1 done", {31'b0, o_done}, 1);
        chk("R1 no writes", {30'b0, o_rdwe, o_rnwe}, 0);
        chk("R1 no flags", {29'b0, o_ill, o_nc, o_ma}, 0);
    endtask

    task automatic t_not_class;
        exec(mk(1,1,1,0,1,4'd1,4'd2,0,0,8'h00), 1'b1, 32'h100, 0, 0, 0, 0);
        chk("R2 swap pattern flagged", {30'b0, o_nc, o_req}, 32'b10);
        exec(mk(1,1,1,0,1,4'd1,4'd2,0,1,8'h00) & ~32'h80, 1'b1, 32'h100, 0, 0, 0, 0);
        chk("R2 bit7 clear flagged", {29'b0, o_nc, o_req, o_done}, 32'b101);
        chk("R2 no writes", {30'b0, o_rdwe, o_rnwe}, 0);
    endtask

    task automatic t_store_half;
        exec(mk(1,1,1,1,0,4'd2,4'd3,0,1,8'h26), 1'b1, 32'h1000, 0, 32'hDEAD_BEEF, 0, 2);
        chk("R4 pre up imm addr", o_addr, 32'h1026);
        chk("R6 be high half", {28'b0, o_be}, 4'b1100);
        chk("R6 wdata replicated", o_wdata, 32'hBEEF_BEEF);
        chk("R6 we", {31'b0, o_we}, 1);
        chk("R12 held while waiting", {31'b0, o_stable}, 1);
        chk("R5 pre W=1 writeback", {31'b0, o_rnwe}, 1);
        chk("R5 new base", o_rndata, 32'h1026);
        chk("R5 rn index", {28'b0, o_rnidx}, 2);
        chk("R6 store no rd write", {31'b0, o_rdwe}, 0);
        exec(mk(1,0,1,0,0,4'd2,4'd3,0,1,8'h04), 1'b1, 32'h2000, 0, 32'h0000_5A5A, 0, 0);
        chk("R4 pre down addr", o_addr, 32'h1FFC);
        chk("R6 be low half", {28'b0, o_be}, 4'b0011);
        chk("R5 pre W=0 no writeback", {31'b0, o_rnwe}, 0);
    endtask

    task automatic t_load_uh;
        exec(mk(0,0,0,0,1,4'd4,4'd5,0,1,8'h07), 1'b1, 32'h3002, 32'h10, 0, 32'h8001_1234, 1);
        chk("R4 post uses base", o_addr, 32'h3002);
        chk("R3 register offset no flag", {31'b0, o_ill}, 0);
        chk("R8 zero-extended high half", o_rddata, 32'h0000_8001);
        chk("R12 rd write", {31'b0, o_rdwe}, 1);
        chk("R12 rd index", {28'b0, o_rdidx}, 5);
        chk("R5 post always writes back", {31'b0, o_rnwe}, 1);
        chk("R5 post new base", o_rndata, 32'h2FF2);
        exec(mk(1,1,1,0,1,4'd4,4'd5,0,1,8'h00), 1'b1, 32'h3000, 0, 0, 32'hFFFF_7FFE, 0);
        chk("R8 zero-extended low half", o_rddata, 32'h0000_7FFE);
    endtask

    task automatic t_load_sb;
        logic [31:0] rd_word = 32'h807F_FF01;
        for (int a = 0; a < 4; a++) begin
            logic [7:0] bv;
            exec(mk(1,1,1,0,1,4'd1,4'd6,1,0,8'(a)), 1'b1, 32'h4000, 0, 0, rd_word, a);
            bv = rd_word[8*a +: 8];
            chk("R9 byte enable", {28'b0, o_be}, 32'(4'b0001 << a));
            chk("R9 sign-extended byte", o_rddata, {{24{bv[7]}}, bv});
        end
    endtask

    task automatic t_load_sh;
        exec(mk(1,1,1,1,1,4'd7,4'd8,1,1,8'h00), 1'b1, 32'h5000, 0, 0, 32'h1234_8765, 0);
        chk("R10 negative low half", o_rddata, 32'hFFFF_8765);
        exec(mk(1,1,1,1,1,4'd7,4'd8,1,1,8'h02), 1'b1, 32'h5000, 0, 0, 32'h1234_8765, 0);
        chk("R10 positive high half", o_rddata, 32'h0000_1234);
        chk("R10 be", {28'b0, o_be}, 4'b1100);
    endtask

    task automatic t_same_reg;
        exec(mk(1,1,1,1,1,4'd9,4'd9,0,1,8'h10), 1'b1, 32'h6000, 0, 0, 32'h0000_ABCD, 0);
        chk("R13 rd written", {31'b0, o_rdwe}, 1);
        chk("R13 loaded value", o_rddata, 32'h0000_ABCD);
        chk("R13 base write suppressed", {31'b0, o_rnwe}, 0);
    endtask

    task automatic t_illegal;
        exec(mk(1,1,1,0,0,4'd1,4'd2,1,0,8'h00), 1'b1, 32'h100, 0, 32'h55, 0, 0);
        chk("R7 signed store flagged", {31'b0, o_ill}, 1);
        chk("R7 no memory access", {31'b0, o_req}, 0);
        exec(mk(0,1,1,1,1,4'd1,4'd2,0,1,8'h02), 1'b1, 32'h100, 0, 0, 0, 0);
        chk("R5 post with W flagged", {30'b0, o_ill, o_req}, 32'b10);
        chk("R5 no write on flag", {30'b0, o_rdwe, o_rnwe}, 0);
        exec(mk(1,1,0,0,1,4'd1,4'd2,0,1,8'h53), 1'b1, 32'h100, 32'h4, 0, 0, 0);
        chk("R3 register offset with nonzero 11:8 flagged", {30'b0, o_ill, o_req}, 32'b10);
    endtask

    task automatic t_misalign;
        exec(mk(1,1,1,0,1,4'd1,4'd2,0,1,8'h01), 1'b1, 32'h100, 0, 0, 0, 0);
        chk("R11 flagged", {30'b0, o_ma, o_done}, 32'b11);
        chk("R11 no access", {31'b0, o_req}, 0);
        chk("R11 no writes", {30'b0, o_rdwe, o_rnwe}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R12 actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; cond_pass = 1'b1; mem_ready = 1'b0;
        instr = 0; base_val = 0; ofs_val = 0; src_val = 0; mem_rdata = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_cond_false();
        t_not_class();
        t_store_half();
        t_load_uh();
        t_load_sb();
        t_load_sh();
        t_same_reg();
        t_illegal();
        t_misalign();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule